// File: doc/BRIEF.md
# SMBus Host Controller Engine

This block is the master side of a two-wire system management bus. Software drives it through a byte-wide register file with eight addresses. It loads a target address with a direction bit, a command code and, for writes, a data byte. It then selects a protocol and sets a start bit in the control register. The engine runs the whole transfer on open-drain clock and data lines. It supports quick, send/receive-byte and write/read-byte-data transfers, and uses a repeated start for the read-byte-data case. It checks every acknowledge and reports the result in a status byte.

Software waits for the busy bit to fall and then reads the status. Exactly one outcome flag is set: done, device error or collision. Writing ones to the status clears those flags, and no new transfer can start until they are clear. A timeout measured in bus clock periods stops a transfer whose clock is held low. The bus clock rate is set by parameters, with a default of 100 kHz from a 200 MHz system clock.

Top module: `smb_host`

## Requirements
- R1: Register offsets are: 0 status, 2 control, 3 command, 4 target address, 5 data0, 6 data1, 7 block data. Offset 1 reads 0. Data1 and block data are plain read/write storage. The status byte reads {4'b0, collision, device error, done, busy} in bits 3..0.
- R2: Control bit 6 is the start bit and always reads 0. All other control bits are stored as written. Bits 4:2 select the protocol: 0 quick, 1 byte, 2 byte-data. A start with any other protocol value produces no bus activity and sets the device error flag (status 0x04).
- R3: A start request is accepted only when busy is low and status bits 3:1 are all zero. Any other start request is ignored.
- R4: Busy (status bit 0) is high for the whole transfer. While busy is high, writes to control, command, address and data0 are ignored.
- R5: When busy falls, exactly one of status bits 3:1 is set. A clean transfer leaves status equal to 0x02.
- R6: Writing 1 to any of status bits 3:1 clears that flag.
- R7: Write transfers. Address register bits 7:1 hold the target and bit 0 is the direction (1 = read). Quick sends only the address byte. Byte write sends the address and then the command register. Byte-data write sends the address, the command and then data0.
- R8: Read transfers. Byte read sends the address with the read bit set and then receives one byte. Byte-data read sends the address with bit 0 forced to 0, then the command, then a repeated start, then the address with read. The last received byte is not acknowledged and is stored in data0.
- R9: If the address or any transmitted byte is not acknowledged, the engine issues a stop and finishes with status 0x04.
- R10: If the data line reads low while the engine releases it for a data bit, that is a collision. The engine issues a stop and finishes with status 0x08.
- R11: A transfer still running after TIMEOUT_SCL bus clock periods is aborted. Both lines are released at once and the status becomes 0x04.
- R12: The lines are only pulled low or released. Both are released whenever the engine is idle. One bus clock period is 4*(CLK_HZ/(4*SCL_HZ)) system clocks, and a target that holds the clock low stretches the period.
- R13: irq is high exactly when control bit 0 is set and any of status bits 3:1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq | output | 1 | Completion interrupt |
| scl_i | input | 1 | Sensed level of the clock line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_i | input | 1 | Sensed level of the data line |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench sweeps a spread of command and data values through every protocol and direction, using a behavioural target on the bus, and predicts each received byte arithmetically. If the engine dropped the repeated start or forgot to force the write bit in the first address phase, the target would return the wrong byte or refuse the address. The bench also injects a refused address, a refused command, a data line held low and a clock held low. An engine that mis-ranked these outcomes would report done, or report two flags, instead of the single expected one. Start requests made while busy or while flags are pending are checked to leave both the bus and the registers untouched. An engine that accepted them would start a second transfer, which shows up in the target's count of start conditions.

// File: rtl/smb_host.sv
module smb_host #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int SCL_HZ      = 100_000,
  parameter int TIMEOUT_SCL = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int QTR    = CLK_HZ / (4 * SCL_HZ);
  localparam int QW     = $clog2(QTR + 1);
  localparam int TO_LIM = TIMEOUT_SCL * 4;
  localparam int TW     = $clog2(TO_LIM + 1);

  localparam logic [2:0] OP_START = 3'd0, OP_ADRW = 3'd1, OP_ADR = 3'd2,
                         OP_CMD = 3'd3, OP_D0 = 3'd4, OP_RX = 3'd5, OP_STOP = 3'd6;

  logic [7:0] ctrl_q, cmd_q, adr_q, d0_q, d1_q, blk_q, sh;
  logic [2:0] flags, seq;
  logic [1:0] ph, ecode;
  logic [3:0] bitn;
  logic       busy, fail, scl_lo, sda_lo;
  logic [QW-1:0] qcnt;
  logic [TW-1:0] tocnt;

  function automatic logic [2:0] op_at(input logic [2:0] p, input logic rd, input logic [2:0] s);
    logic [2:0] r;
    r = OP_STOP;
    if (s == 3'd0) r = OP_START;
    else if (p == 3'd0) begin
      if (s == 3'd1) r = OP_ADR;
    end else if (p == 3'd1) begin
      if (s == 3'd1) r = OP_ADR;
      else if (s == 3'd2) r = rd ? OP_RX : OP_CMD;
    end else if (!rd) begin
      if (s == 3'd1) r = OP_ADR;
      else if (s == 3'd2) r = OP_CMD;
      else if (s == 3'd3) r = OP_D0;
    end else begin
      case (s)
        3'd1: r = OP_ADRW;
        3'd2: r = OP_CMD;
        3'd3: r = OP_START;
        3'd4: r = OP_ADR;
        3'd5: r = OP_RX;
        default: r = OP_STOP;
      endcase
    end
    return r;
  endfunction

  logic [2:0] op, nop;
  logic [7:0] nxt_byte;
  logic       tick, is_tx, launch;

  assign op    = fail ? OP_STOP : op_at(ctrl_q[4:2], adr_q[0], seq);
  assign nop   = op_at(ctrl_q[4:2], adr_q[0], 3'(seq + 3'd1));
  assign is_tx = (op == OP_ADRW) || (op == OP_ADR) || (op == OP_CMD) || (op == OP_D0);
  assign tick  = busy && (qcnt == QW'(QTR - 1));
  assign launch = reg_wr && (reg_addr == 3'd2) && reg_wdata[6] && !busy && (flags == 3'b000);

  always_comb begin
    case (nop)
      OP_ADRW: nxt_byte = {adr_q[7:1], 1'b0};
      OP_ADR:  nxt_byte = adr_q;
      OP_CMD:  nxt_byte = cmd_q;
      OP_D0:   nxt_byte = d0_q;
      default: nxt_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {4'b0000, flags, busy};
      3'd2: reg_rdata = ctrl_q;
      3'd3: reg_rdata = cmd_q;
      3'd4: reg_rdata = adr_q;
      3'd5: reg_rdata = d0_q;
      3'd6: reg_rdata = d1_q;
      3'd7: reg_rdata = blk_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq    = ctrl_q[0] && (flags != 3'b000);
  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; cmd_q <= '0; adr_q <= '0; d0_q <= '0; d1_q <= '0; blk_q <= '0;
      sh <= '0; flags <= '0; seq <= '0; ph <= '0; ecode <= '0; bitn <= '0;
      busy <= 1'b0; fail <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
      qcnt <= '0; tocnt <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: flags <= flags & ~reg_wdata[3:1];
          3'd2: if (!busy) ctrl_q <= reg_wdata & 8'hBF;
          3'd3: if (!busy) cmd_q <= reg_wdata;
          3'd4: if (!busy) adr_q <= reg_wdata;
          3'd5: if (!busy) d0_q <= reg_wdata;
          3'd6: d1_q <= reg_wdata;
          3'd7: blk_q <= reg_wdata;
          default: ;
        endcase
      end
      if (launch) begin
        if (reg_wdata[4:2] > 3'd2) flags <= 3'b010;
        else begin
          busy <= 1'b1; seq <= '0; ph <= '0; bitn <= '0;
          ecode <= '0; fail <= 1'b0; tocnt <= '0;
        end
      end
      qcnt <= (!busy || tick) ? '0 : qcnt + 1'b1;
      if (tick) begin
        if (tocnt == TW'(TO_LIM - 1)) begin
          busy <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0; flags <= 3'b010;
          fail <= 1'b0; ecode <= '0;
        end else begin
          tocnt <= tocnt + 1'b1;
          if (!(ph == 2'd2 && !scl_i)) begin
            ph <= ph + 2'd1;
            case (op)
              OP_START: case (ph)
                2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b0; end
                2'd1: scl_lo <= 1'b0;
                2'd2: sda_lo <= 1'b1;
                default: begin scl_lo <= 1'b1; seq <= seq + 3'd1; sh <= nxt_byte; end
              endcase
              OP_STOP: case (ph)
                2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
                2'd1: scl_lo <= 1'b0;
                2'd2: sda_lo <= 1'b0;
                default: begin
                  busy <= 1'b0; fail <= 1'b0; ecode <= '0;
                  flags <= (ecode == 2'd2) ? 3'b100 : (ecode == 2'd1) ? 3'b010 : 3'b001;
                end
              endcase
              default: case (ph)
                2'd0: begin scl_lo <= 1'b1; sda_lo <= is_tx && !bitn[3] && !sh[7]; end
                2'd1: scl_lo <= 1'b0;
                2'd2: begin
                  if (is_tx) begin
                    if (!bitn[3] && sh[7] && !sda_i) ecode <= 2'd2;
                    else if (bitn[3] && sda_i) ecode <= 2'd1;
                  end else if (!bitn[3]) sh <= {sh[6:0], sda_i};
                end
                default: begin
                  scl_lo <= 1'b1;
                  if (ecode != 2'd0) begin
                    fail <= 1'b1; bitn <= '0;
                  end else if (bitn[3]) begin
                    if (op == OP_RX) d0_q <= sh;
                    bitn <= '0; seq <= seq + 3'd1; sh <= nxt_byte;
                  end else begin
                    bitn <= bitn + 4'd1;
                    if (is_tx) sh <= {sh[6:0], 1'b0};
                  end
                end
              endcase
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [2:0] flags,
  input logic [2:0] proto,
  input logic [7:0] cmd_q,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       scl_oe,
  input logic       sda_oe
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $countones(flags) == 1); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R12
  AST_LAUNCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(flags) == 3'b000); // R3
  AST_PROTO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> proto <= 3'd2); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd3) |=> $stable(cmd_q)); // R4
endmodule

bind smb_host smb_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .flags(flags), .proto(ctrl_q[4:2]),
  .cmd_q(cmd_q), .reg_wr(reg_wr), .reg_addr(reg_addr), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_smb_host.sv
module tb_smb_host;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic hold_scl = 1'b0, hold_sda = 1'b0, nack_cmd = 1'b0;
  logic s_lo = 1'b0;
  wire scl_bus = !(scl_oe || hold_scl);
  wire sda_bus = !(sda_oe || s_lo || hold_sda);

  int n_cmp = 0, n_bad = 0, s_starts = 0, scl_seen = 0;
  logic done_flag = 1'b0;

  always #2.5 clk = ~clk;

  smb_host #(.CLK_HZ(8_000_000), .SCL_HZ(1_000_000), .TIMEOUT_SCL(64)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_i(scl_bus), .scl_oe(scl_oe),
    .sda_i(sda_bus), .sda_oe(sda_oe));

  function automatic logic [7:0] rval(input logic [7:0] c);
    return c ^ 8'hA5;
  endfunction

  logic p_scl = 1'b1, p_sda = 1'b1, s_act = 1'b0, s_send = 1'b0;
  logic [3:0] s_cnt = '0, s_idx = '0;
  logic [7:0] s_txb = '0, s_rxb = '0, s_cmd = '0, s_data = '0;

  always @(posedge clk) begin
    p_scl <= scl_bus;
    p_sda <= sda_bus;
    if (scl_oe) scl_seen <= scl_seen + 1;
    if (p_scl && scl_bus && p_sda && !sda_bus) begin
      s_act <= 1'b1; s_cnt <= '0; s_idx <= '0; s_send <= 1'b0; s_lo <= 1'b0;
      s_starts <= s_starts + 1;
    end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
      s_act <= 1'b0; s_lo <= 1'b0;
    end else if (s_act && !p_scl && scl_bus) begin
      if (s_cnt < 4'd8) begin
        if (!s_send) s_rxb <= {s_rxb[6:0], sda_bus};
        s_cnt <= s_cnt + 4'd1;
      end else if (s_cnt == 4'd9 && s_send && sda_bus) begin
        s_act <= 1'b0; s_send <= 1'b0;
      end
    end else if (s_act && p_scl && !scl_bus) begin
      if (s_cnt == 4'd8) begin
        s_cnt <= 4'd9;
        if (s_send) s_lo <= 1'b0;
        else if (s_idx == 4'd0) begin
          if (s_rxb[7:1] == SLV) begin
            s_lo <= 1'b1;
            if (s_rxb[0]) begin s_send <= 1'b1; s_txb <= rval(s_cmd); end
          end else s_act <= 1'b0;
        end else if (s_idx == 4'd1) begin
          if (nack_cmd) s_act <= 1'b0;
          else begin s_lo <= 1'b1; s_cmd <= s_rxb; end
        end else begin
          s_lo <= 1'b1; s_data <= s_rxb;
        end
      end else if (s_cnt == 4'd9) begin
        s_cnt <= '0; s_idx <= s_idx + 4'd1;
        s_lo <= s_send ? !s_txb[7] : 1'b0;
      end else if (s_send) s_lo <= !s_txb[3'd7 - s_cnt[2:0]];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic go(input logic [2:0] proto, input logic rdir, input logic [7:0] c, input logic [7:0] d);
    wr(3'd4, {SLV, rdir});
    wr(3'd3, c);
    wr(3'd5, d);
    wr(3'd2, {3'b010, proto, 2'b00});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v, c, d;
    int st0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R5 reset status", v, 8'h00);
    rd(3'd2, v); chk("R2 reset control", v, 8'h00);
    chk("R12 lines released after reset", {6'b0, scl_oe, sda_oe}, 8'h00);
    chk("R13 irq low after reset", {7'b0, irq}, 8'h00);

    wr(3'd6, 8'h5A); wr(3'd7, 8'hC3); wr(3'd1, 8'hFF);
    rd(3'd6, v); chk("R1 data1 storage", v, 8'h5A);
    rd(3'd7, v); chk("R1 block storage", v, 8'hC3);
    rd(3'd1, v); chk("R1 offset 1 reads zero", v, 8'h00);
    wr(3'd2, 8'hBD);
    rd(3'd2, v); chk("R2 control bits kept", v, 8'hBD);
    wr(3'd2, 8'h00);

    scl_seen = 0;
    wr(3'd2, 8'h5C);
    repeat (20) @(negedge clk);
    rd(3'd0, v); chk("R2 bad protocol device error", v, 8'h04);
    chk("R2 no bus activity", 8'(scl_seen), 8'h00);
    wr(3'd0, 8'h0E);
    rd(3'd0, v); chk("R6 clear all flags", v, 8'h00);

    for (int k = 0; k < 8; k++) begin
      c = 8'(k * 37 + 1);
      d = ~c;
      go(3'd0, 1'b0, c, d); wait_idle();
      rd(3'd0, v); chk("R7 quick write status", v, 8'h02);
      wr(3'd0, 8'h02);
      rd(3'd0, v); chk("R6 done cleared", v, 8'h00);
      go(3'd1, 1'b0, c, d); wait_idle();
      rd(3'd0, v); chk("R7 byte write status", v, 8'h02);
      chk("R7 byte write command at target", s_cmd, c);
      wr(3'd0, 8'h02);
      go(3'd2, 1'b0, c, d); wait_idle();
      rd(3'd0, v); chk("R7 byte-data write status", v, 8'h02);
      chk("R7 byte-data write command", s_cmd, c);
      chk("R7 byte-data write data", s_data, d);
      wr(3'd0, 8'h02);
      go(3'd2, 1'b1, c, 8'h00); wait_idle();
      rd(3'd0, v); chk("R8 byte-data read status", v, 8'h02);
      rd(3'd5, v); chk("R8 byte-data read data0", v, rval(c));
      wr(3'd0, 8'h02);
      go(3'd1, 1'b1, 8'h00, 8'h00); wait_idle();
      rd(3'd0, v); chk("R8 byte read status", v, 8'h02);
      rd(3'd5, v); chk("R8 byte read data0", v, rval(c));
      wr(3'd0, 8'h02);
    end

    st0 = s_starts;
    go(3'd2, 1'b1, 8'h11, 8'h00);
    rd(3'd0, v); chk("R4 busy during transfer", v & 8'h01, 8'h01);
    wr(3'd3, 8'h99);
    wr(3'd2, 8'h44);
    wait_idle();
    rd(3'd3, v); chk("R4 command write ignored while busy", v, 8'h11);
    rd(3'd2, v); chk("R4 control write ignored while busy", v, 8'h08);
    rd(3'd5, v); chk("R8 data0 after ignored writes", v, rval(8'h11));
    chk("R3 one transfer only (two starts)", 8'(s_starts - st0), 8'h02);

    st0 = s_starts;
    wr(3'd2, 8'h40);
    repeat (30) @(negedge clk);
    rd(3'd0, v); chk("R3 start ignored with flag pending", v, 8'h02);
    chk("R3 no start condition", 8'(s_starts - st0), 8'h00);
    wr(3'd0, 8'h02);

    wr(3'd4, 8'h66); wr(3'd2, 8'h40); wait_idle();
    rd(3'd0, v); chk("R9 address refused", v, 8'h04);
    wr(3'd0, 8'h04);
    nack_cmd = 1'b1;
    go(3'd2, 1'b0, 8'h21, 8'h22); wait_idle();
    rd(3'd0, v); chk("R9 command refused", v, 8'h04);
    wr(3'd0, 8'h04);
    nack_cmd = 1'b0;

    go(3'd0, 1'b0, 8'h00, 8'h00);
    repeat (8) @(negedge clk);
    hold_sda = 1'b1;
    wait_idle();
    rd(3'd0, v); chk("R10 collision flag", v, 8'h08);
    hold_sda = 1'b0;
    wr(3'd0, 8'h08);
    rd(3'd0, v); chk("R6 collision cleared", v, 8'h00);

    hold_scl = 1'b1;
    go(3'd0, 1'b0, 8'h00, 8'h00); wait_idle();
    rd(3'd0, v); chk("R11 timeout device error", v, 8'h04);
    chk("R11 lines released on timeout", {6'b0, scl_oe, sda_oe}, 8'h00);
    hold_scl = 1'b0;
    wr(3'd0, 8'h04);
    repeat (10) @(negedge clk);

    wr(3'd4, {SLV, 1'b0});
    wr(3'd2, 8'h41);
    rd(3'd0, v); chk("R13 irq low while busy", {7'b0, irq}, 8'h00);
    wait_idle();
    rd(3'd0, v); chk("R5 clean quick with irq enabled", v, 8'h02);
    chk("R13 irq raised on completion", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h02);
    chk("R13 irq low after clear", {7'b0, irq}, 8'h00);
    chk("R12 lines released at end", {6'b0, scl_oe, sda_oe}, 8'h00);

    done_flag = 1'b1;
    finish_run();
  end
endmodule